// File: doc/BRIEF.md
# Multi-Channel Coincidence Trigger

This block sits after the per-channel trigger logic of a four-channel waveform digitizer. Each channel reports an event of interest as a single-cycle pulse. The block counts how many *different* channels have reported within a programmable time span. When that number reaches a programmable threshold, it issues a master trigger.

On the master trigger the block also raises a freeze signal. This signal stops every channel so that the stored samples stay intact while a supervising controller reads them out. The freeze is held in a latch and does not depend on later channel activity. It is released only when the controller pulses the rearm input.

Each channel has a countdown timer. A channel pulse reloads its timer with the window length, and the channel counts as active while its timer is nonzero. The number of active channels is compared against the threshold on every cycle. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `coinc_trigger`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `master_trig` and `freeze` are 0, and no channel is active.
- R2: A pulse on `ch_hit[i]` sampled at clock edge k makes channel i active for exactly `cfg_window` cycles, covering the states after edges k through k+`cfg_window`-1. A new pulse on the same channel restarts its span. A window of 0 never makes a channel active.
- R3: When the number of active channels, after some edge, is at least `cfg_level`, `master_trig` is 1 for exactly one cycle after the next edge. This holds only if `freeze` is low and `rearm` is low.
- R4: Only distinct channels count. Repeated pulses on one channel add at most one to the active count.
- R5: A `cfg_level` of 0, or any value above 4, never produces `master_trig`. `cfg_level` is an unsigned 3-bit count of channels.
- R6: `freeze` rises together with `master_trig` and stays high until a rearm is sampled. No further `master_trig` occurs while it is high, and channel pulses sampled while it is high have no effect.
- R7: A rearm sampled at an edge clears `freeze` and every channel timer after that edge. Rearm takes priority over a coincidence at the same edge, which then produces no `master_trig`.
- R8: With `cfg_level` = 2, pulses on two channels sampled at edges k1 < k2 give a master trigger exactly when k2 − k1 < `cfg_window`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_hit | input | NUM_CH (4) | Per-channel trigger pulses, bit i for channel i |
| cfg_level | input | LVL_W (3) | Number of distinct channels required |
| cfg_window | input | WIN_W (16) | Coincidence span in clock cycles |
| rearm | input | 1 | Releases the freeze and clears all channel timers |
| master_trig | output | 1 | Single-cycle coincidence pulse |
| freeze | output | 1 | Latched halt of all channels |

## Verification
The bench builds the block with four channels and an 8-bit window field. This keeps windows of a few cycles short to simulate, while still testing the off-by-one edge of the span: a gap of window−1 must fire and a gap equal to the window must not. The 3-bit level field lets the bench apply 0 and 5, so both disabled encodings are tested along with every real threshold up to four of four. A behavioural model runs on every cycle alongside directed scenarios. Those scenarios cover retriggering, repeated pulses on one channel, pulses during a freeze, and a rearm arriving in the same cycle as a coincidence.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  typedef enum logic {
    ARMED  = 1'b0,
    FROZEN = 1'b1
  } acq_state_e;
endpackage

// File: rtl/ch_window_timer.sv
module ch_window_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             block,
  input  logic             hit,
  input  logic [WIN_W-1:0] window,
  output logic             active
);
  logic [WIN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      remain <= '0;
    end else if (hit && !block) begin
      remain <= window;
    end else if (remain != '0) begin
      remain <= remain - WIN_W'(1);
    end
  end

  assign active = (remain != '0);
endmodule

// File: rtl/active_counter.sv
module active_counter #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 3
) (
  input  logic [NUM_CH-1:0] act,
  output logic [CNT_W-1:0]  count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      count = count + CNT_W'(act[i]);
    end
  end
endmodule

// File: rtl/halt_ctrl.sv
module halt_ctrl
  import coinc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LVL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] count,
  input  logic [LVL_W-1:0] level,
  input  logic             rearm,
  output logic             master_trig,
  output logic             freeze
);
  localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(NUM_CH);

  acq_state_e state;
  logic       level_ok;
  logic       met;

  assign level_ok = (level != '0) && (level <= MAX_LVL);
  assign met      = level_ok && (count >= level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ARMED;
      master_trig <= 1'b0;
    end else if (rearm) begin
      state       <= ARMED;
      master_trig <= 1'b0;
    end else if (state == ARMED && met) begin
      state       <= FROZEN;
      master_trig <= 1'b1;
    end else begin
      master_trig <= 1'b0;
    end
  end

  assign freeze = (state == FROZEN);
endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger #(
  parameter int NUM_CH = 4,
  parameter int WIN_W  = 16,
  parameter int LVL_W  = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_hit,
  input  logic [LVL_W-1:0]  cfg_level,
  input  logic [WIN_W-1:0]  cfg_window,
  input  logic              rearm,
  output logic              master_trig,
  output logic              freeze
);
  logic [NUM_CH-1:0] ch_active;
  logic [LVL_W-1:0]  active_cnt;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ch_window_timer #(.WIN_W(WIN_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (rearm),
      .block  (freeze),
      .hit    (ch_hit[g]),
      .window (cfg_window),
      .active (ch_active[g])
    );
  end

  active_counter #(.NUM_CH(NUM_CH), .CNT_W(LVL_W)) u_cnt (
    .act   (ch_active),
    .count (active_cnt)
  );

  halt_ctrl #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_halt (
    .clk         (clk),
    .rst_n       (rst_n),
    .count       (active_cnt),
    .level       (cfg_level),
    .rearm       (rearm),
    .master_trig (master_trig),
    .freeze      (freeze)
  );
endmodule

// File: rtl/coinc_trigger_chk.sv
module coinc_trigger_chk #(
  parameter int NUM_CH = 4,
  parameter int LVL_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             master_trig,
  input logic             freeze,
  input logic             rearm,
  input logic [LVL_W-1:0] cfg_level,
  input logic [LVL_W-1:0] active_cnt
);
  localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(NUM_CH);

  // R3: single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    master_trig |=> !master_trig);

  // R3: a pulse needs enough active channels at the previous edge
  a_r3_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
    master_trig |-> $past(active_cnt >= cfg_level));

  // R3: enough active channels while armed produces the pulse
  a_r3_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !rearm && cfg_level != '0 && cfg_level <= MAX_LVL
     && active_cnt >= cfg_level) |=> master_trig);

  // R5: disabled levels never produce a pulse
  a_r5_disabled_level: assert property (@(posedge clk) disable iff (!rst_n)
    master_trig |-> ($past(cfg_level) != '0 && $past(cfg_level) <= MAX_LVL));

  // R6: freeze accompanies the pulse and holds until rearm
  a_r6_freeze_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    master_trig |-> freeze);

  a_r6_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !rearm) |=> freeze);

  a_r6_no_pulse_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> !master_trig);

  // R7: rearm releases and wins over a coincidence
  a_r7_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (!freeze && !master_trig && active_cnt == '0));
endmodule

bind coinc_trigger coinc_trigger_chk #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .master_trig (master_trig),
  .freeze      (freeze),
  .rearm       (rearm),
  .cfg_level   (cfg_level),
  .active_cnt  (active_cnt)
);

// File: tb/coinc_trigger_bench.sv
module coinc_trigger_bench;
  localparam int NUM_CH = 4;
  localparam int WIN_W  = 8;
  localparam int LVL_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_CH-1:0] ch_hit = '0;
  logic [LVL_W-1:0]  cfg_level = 3'd1;
  logic [WIN_W-1:0]  cfg_window = 8'd4;
  logic              rearm = 1'b0;
  logic              master_trig;
  logic              freeze;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  coinc_trigger #(.NUM_CH(NUM_CH), .WIN_W(WIN_W), .LVL_W(LVL_W)) u_coinc_trigger (
    .clk(clk), .rst_n(rst_n), .ch_hit(ch_hit), .cfg_level(cfg_level),
    .cfg_window(cfg_window), .rearm(rearm), .master_trig(master_trig), .freeze(freeze)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_tmr[NUM_CH];
  bit m_master = 0;
  bit m_frozen = 0;

  always @(posedge clk) begin
    int  act;
    bit  ok;
    bit  met;
    act = 0;
    foreach (m_tmr[i]) if (m_tmr[i] > 0) act++;
    ok  = (cfg_level >= 1) && (cfg_level <= NUM_CH);
    met = ok && (act >= int'(cfg_level));
    if (!rst_n) begin
      foreach (m_tmr[i]) m_tmr[i] = 0;
      m_master = 0;
      m_frozen = 0;
    end else begin
      foreach (m_tmr[i]) begin
        if (rearm) m_tmr[i] = 0;
        else if (!m_frozen && ch_hit[i]) m_tmr[i] = int'(cfg_window);
        else if (m_tmr[i] > 0) m_tmr[i]--;
      end
      m_master = !rearm && !m_frozen && met;
      m_frozen = !rearm && (m_frozen || met);
    end
  end

  always @(negedge clk) begin
    if (master_trig) pulses++;
    if (rst_n) begin
      chk("R3 model master_trig", int'(master_trig), int'(m_master));
      chk("R6 model freeze", int'(freeze), int'(m_frozen));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic hit(input logic [NUM_CH-1:0] m);
    @(negedge clk) ch_hit = m;
    @(negedge clk) ch_hit = '0;
  endtask

  task automatic hit2(input logic [NUM_CH-1:0] m1, input logic [NUM_CH-1:0] m2, input int gap);
    @(negedge clk) ch_hit = m1;
    for (int i = 1; i < gap; i++) begin
      @(negedge clk) ch_hit = '0;
    end
    @(negedge clk) ch_hit = m2;
    @(negedge clk) ch_hit = '0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic do_rearm();
    @(negedge clk) rearm = 1'b1;
    @(negedge clk) rearm = 1'b0;
    repeat (12) @(negedge clk);
    #1;
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset master_trig", int'(master_trig), 0);
    chk("R1 reset freeze", int'(freeze), 0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 after reset freeze", int'(freeze), 0);

    // R3 / R6: level 1 fires on any channel
    cfg_level = 3'd1; cfg_window = 8'd4;
    base = pulses;
    hit(4'b0100); settle();
    chk("R3 level1 pulse count", pulses - base, 1);
    chk("R6 freeze latched", int'(freeze), 1);

    // R6: pulses while frozen are ignored
    hit(4'b1111); hit(4'b0011); settle();
    chk("R6 no pulse while frozen", pulses - base, 1);
    chk("R6 freeze still high", int'(freeze), 1);

    // R7: rearm releases
    do_rearm();
    chk("R7 rearm clears freeze", int'(freeze), 0);

    // R3: three of four
    cfg_level = 3'd3; cfg_window = 8'd8;
    base = pulses;
    hit(4'b0011); settle();
    chk("R3 two of three short", pulses - base, 0);
    hit(4'b1000); settle();
    chk("R3 third channel fires", pulses - base, 1);
    do_rearm();

    // R4: one channel repeating does not satisfy level 2
    cfg_level = 3'd2;
    base = pulses;
    @(negedge clk) ch_hit = 4'b0001;
    @(negedge clk) ch_hit = 4'b0001;
    @(negedge clk) ch_hit = 4'b0001;
    @(negedge clk) ch_hit = 4'b0000;
    settle();
    chk("R4 repeated channel counted once", pulses - base, 0);
    do_rearm();

    // R8: boundary of the span, window 5
    cfg_level = 3'd2; cfg_window = 8'd5;
    base = pulses;
    hit2(4'b0001, 4'b0010, 4); settle();
    chk("R8 gap 4 inside window 5", pulses - base, 1);
    do_rearm();
    base = pulses;
    hit2(4'b0001, 4'b0010, 5); settle();
    chk("R8 gap 5 outside window 5", pulses - base, 0);
    do_rearm();

    // R2: retrigger extends the span, window 3
    cfg_window = 8'd3;
    base = pulses;
    @(negedge clk) ch_hit = 4'b0001;
    @(negedge clk) ch_hit = 4'b0000;
    @(negedge clk) ch_hit = 4'b0001;
    @(negedge clk) ch_hit = 4'b0000;
    @(negedge clk) ch_hit = 4'b0010;
    @(negedge clk) ch_hit = 4'b0000;
    settle();
    chk("R2 retrigger restarts span", pulses - base, 1);
    do_rearm();

    // R2: window 0 never active
    cfg_level = 3'd1; cfg_window = 8'd0;
    base = pulses;
    hit(4'b1111); settle();
    chk("R2 zero window inactive", pulses - base, 0);
    do_rearm();

    // R5: disabled levels
    cfg_window = 8'd8; cfg_level = 3'd0;
    base = pulses;
    hit(4'b1111); settle();
    chk("R5 level 0 disabled", pulses - base, 0);
    do_rearm();
    cfg_level = 3'd5;
    hit(4'b1111); settle();
    chk("R5 level 5 disabled", pulses - base, 0);
    do_rearm();
    cfg_level = 3'd4;
    hit(4'b1111); settle();
    chk("R3 four of four", pulses - base, 1);
    do_rearm();

    // R7: rearm wins over a coincidence at the same edge
    cfg_level = 3'd2;
    base = pulses;
    @(negedge clk) ch_hit = 4'b0011;
    @(negedge clk) begin ch_hit = 4'b0000; rearm = 1'b1; end
    @(negedge clk) rearm = 1'b0;
    settle();
    chk("R7 rearm priority no pulse", pulses - base, 0);
    chk("R7 rearm priority freeze", int'(freeze), 0);

    // R7: rearm while armed clears timers
    cfg_window = 8'd20;
    base = pulses;
    hit(4'b0001);
    @(negedge clk) rearm = 1'b1;
    @(negedge clk) rearm = 1'b0;
    hit(4'b0010); settle();
    chk("R7 rearm clears timers", pulses - base, 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule